// File: doc/BRIEF.md
# Multi-input wake-up debouncer

This block merges up to fourteen external wake-up pins into one request to power up the core supply. Each pin has an enable bit and a polarity bit. The polarity picks which level counts as active: low (entered by a falling edge) or high (entered by a rising edge). One debounce counter is shared by all pins. It runs on the slow clock and decides how long the combined active condition must hold before a wake-up is requested.

When the counter reaches the programmed hold time, the block raises a single-cycle wake pulse. It also latches which enabled pins were active at that edge. A sticky summary flag and the per-pin snapshot stay set until a status read clears them. If a read and a new trigger land on the same edge, the new capture survives and everything older is dropped.

Top module: `pin_wake_debouncer`

## Requirements
- R1: After reset, `wake`, `wake_flag` and `pin_status` are all zero.
- R2: A pin whose bit in `pin_en` is 0 has no wake-up effect, whatever its level.
- R3: A pin is active when its level equals its bit in `pin_pol`: 0 selects active-low, 1 selects active-high. The combined condition is the OR of all enabled, active pins.
- R4: `hold_sel` sets how many consecutive slow-clock edges must see the combined condition before `wake` is set:
  - 0: one edge
  - 1: 3 edges
  - 2: 32 edges
  - 3: 512 edges
  - 4: 4096 edges
  - 5: 32768 edges
  - 6 and 7: 32768 edges

  `wake` is high in the cycle after the edge that completes the count.
- R5: Any edge that sees the combined condition inactive restarts the count from zero.
- R6: `wake` is a one-cycle pulse. It fires at most once per continuous active stretch, and only fires again after the condition has gone inactive.
- R7: `wake_flag` is set by every trigger and stays set until an edge with `status_rd` high clears it, together with `pin_status`.
- R8: On a trigger, bit i of `pin_status` is set exactly when pin i is enabled and active at that edge. Bits are sticky until read.
- R9: If `status_rd` and a trigger occur on the same edge, `pin_status` holds only the bits captured by that trigger, and `wake_flag` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins | input | 14 | External wake-up pin levels |
| pin_en | input | 14 | Per-pin enable |
| pin_pol | input | 14 | Per-pin polarity, 1 = active high |
| hold_sel | input | 3 | Debounce hold-time code |
| status_rd | input | 1 | Status read strobe, clears flag and snapshot |
| wake | output | 1 | One-cycle wake-up request pulse |
| wake_flag | output | 1 | Sticky: a pin wake-up happened since last read |
| pin_status | output | 14 | Sticky snapshot of pins that caused triggers |

## Verification
The status read and a debouncer trigger can land on the same slow-clock edge. That is the one place where clearing and capturing compete.

The bench provokes this case as follows:
1. It leaves an older capture on one pin without reading it.
2. It lets the condition go inactive.
3. With the zero-length hold, it activates a second pin on the same edge that carries the read strobe.

The result passes only if the snapshot holds just the second pin and the flag stays set. A later plain read must then clear both.

// File: rtl/pin_wake_debouncer.sv
module pin_wake_debouncer #(
  parameter int NPINS   = 14,
  parameter int CNT_W   = 16,
  parameter int HOLD_C1 = 3,
  parameter int HOLD_C2 = 32,
  parameter int HOLD_C3 = 512,
  parameter int HOLD_C4 = 4096,
  parameter int HOLD_C5 = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins,
  input  logic [NPINS-1:0] pin_en,
  input  logic [NPINS-1:0] pin_pol,
  input  logic [2:0]       hold_sel,
  input  logic             status_rd,
  output logic             wake,
  output logic             wake_flag,
  output logic [NPINS-1:0] pin_status
);

  localparam logic [CNT_W:0] N0 = 1;
  localparam logic [CNT_W:0] N1 = HOLD_C1[CNT_W:0];
  localparam logic [CNT_W:0] N2 = HOLD_C2[CNT_W:0];
  localparam logic [CNT_W:0] N3 = HOLD_C3[CNT_W:0];
  localparam logic [CNT_W:0] N4 = HOLD_C4[CNT_W:0];
  localparam logic [CNT_W:0] N5 = HOLD_C5[CNT_W:0];

  logic [NPINS-1:0] hit;
  logic             cond;
  logic [CNT_W:0]   need;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_inc;
  logic             fired;
  logic             trig;

  assign hit     = pin_en & ~(pins ^ pin_pol);
  assign cond    = |hit;
  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign trig    = cond && !fired && (cnt_inc >= need);

  always_comb begin
    case (hold_sel)
      3'd0:    need = N0;
      3'd1:    need = N1;
      3'd2:    need = N2;
      3'd3:    need = N3;
      3'd4:    need = N4;
      default: need = N5;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      fired      <= 1'b0;
      wake       <= 1'b0;
      wake_flag  <= 1'b0;
      pin_status <= '0;
    end else begin
      if (!cond) begin
        cnt   <= '0;
        fired <= 1'b0;
      end else begin
        if (cnt_inc <= need) cnt <= cnt_inc[CNT_W-1:0];
        if (trig) fired <= 1'b1;
      end
      wake <= trig;
      if (trig) begin
        wake_flag  <= 1'b1;
        pin_status <= (status_rd ? '0 : pin_status) | hit;
      end else if (status_rd) begin
        wake_flag  <= 1'b0;
        pin_status <= '0;
      end
    end
  end

  // R6
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !wake);

  // R2
  no_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(pin_en & ~(pins ^ pin_pol))) |=> !wake);

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> (wake || !wake_flag));

  // R8
  status_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pin_status) |-> wake_flag);

  // R9
  wake_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (wake_flag && (|pin_status)));

endmodule

// File: tb/pin_wake_debouncer_test.sv
`timescale 1ns/1ps
module pin_wake_debouncer_test;
  localparam int NP = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic [NP-1:0] pin_en = '0;
  logic [NP-1:0] pin_pol = '0;
  logic [2:0]    hold_sel = '0;
  logic          status_rd = 1'b0;
  logic          wake, wake_flag;
  logic [NP-1:0] pin_status;

  int nchk = 0;
  int nbad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pin_wake_debouncer uut (
    .clk(clk), .rst_n(rst_n), .pins(pins), .pin_en(pin_en), .pin_pol(pin_pol),
    .hold_sel(hold_sel), .status_rd(status_rd), .wake(wake),
    .wake_flag(wake_flag), .pin_status(pin_status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic run(input int n, inout int seen);
    for (int k = 0; k < n; k++) begin
      step();
      if (wake) seen++;
    end
  endtask

  task automatic do_read();
    status_rd = 1'b1;
    step();
    status_rd = 1'b0;
  endtask

  function automatic int hold_len(input int code);
    case (code)
      0: return 1;
      1: return 3;
      2: return 32;
      3: return 512;
      4: return 4096;
      default: return 32768;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    int seen;
    repeat (3) step();
    // R1 reset state
    chk("R1 wake", wake, 0);
    chk("R1 flag", wake_flag, 0);
    chk("R1 status", pin_status, 0);
    rst_n = 1'b1;
    step();

    // R2 disabled pins at active level never wake
    pin_en = '0; pin_pol = '0; pins = '0; hold_sel = 0;
    seen = 0;
    run(20, seen);
    chk("R2 disabled wakes", seen, 0);
    chk("R2 flag", wake_flag, 0);
    chk("R2 status", pin_status, 0);

    // R3/R8 sweep every pin, both polarities, with a disabled active neighbour
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < NP; i++) begin
        int j;
        j = (i + 1) % NP;
        pin_pol = p ? '1 : '0;
        pins = p ? '0 : '1;
        pin_en = ~(NP'(1) << j);
        step();
        pins[i] = p[0];
        pins[j] = p[0];
        step();
        chk("R3 wake on active pin", wake, 1);
        chk("R8 snapshot", pin_status, NP'(1) << i);
        chk("R7 flag set", wake_flag, 1);
        pins = p ? '0 : '1;
        step();
        chk("R6 pulse ends", wake, 0);
        do_read();
        chk("R7 flag cleared", wake_flag, 0);
        chk("R7 status cleared", pin_status, 0);
      end
    end

    // R4 hold length sweep, R6 single fire while held
    pin_en = 14'h0001; pin_pol = 14'h0001; pins = '0;
    for (int c = 0; c < 7; c++) begin
      int n;
      n = hold_len(c);
      hold_sel = 3'(c);
      step();
      pins[0] = 1'b1;
      seen = 0;
      run(n - 1, seen);
      chk("R4 early wake", seen, 0);
      step();
      chk("R4 wake at hold end", wake, 1);
      seen = 0;
      run(40, seen);
      chk("R6 no refire while held", seen, 0);
      pins[0] = 1'b0;
      step();
      do_read();
    end

    // R5 interruption restarts the count
    hold_sel = 2;
    pins[0] = 1'b1;
    seen = 0;
    run(31, seen);
    pins[0] = 1'b0;
    run(1, seen);
    pins[0] = 1'b1;
    run(31, seen);
    chk("R5 no wake after restart", seen, 0);
    step();
    chk("R5 wake after full hold", wake, 1);
    pins[0] = 1'b0;
    step();

    // R7 flag persists without read
    seen = 0;
    run(10, seen);
    chk("R7 flag sticky", wake_flag, 1);
    chk("R8 status sticky", pin_status, 14'h0001);
    do_read();
    chk("R7 cleared by read", wake_flag, 0);

    // R9 read coinciding with a trigger
    hold_sel = 0;
    pin_en = 14'h0024; pin_pol = 14'h0024; pins = '0;
    step();
    pins[2] = 1'b1;
    step();
    pins[2] = 1'b0;
    step();
    chk("R9 old capture", pin_status, 14'h0004);
    pins[5] = 1'b1;
    status_rd = 1'b1;
    step();
    status_rd = 1'b0;
    chk("R9 new bits kept", pin_status, 14'h0020);
    chk("R9 flag kept", wake_flag, 1);
    pins[5] = 1'b0;
    step();
    do_read();
    chk("R9 later read clears", pin_status, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule